// File: doc/BRIEF.md
# Sv32 Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table held in physical memory. It keeps a root register that software loads through a single write port. The top bit of the written word enables translation. When it is set, the low 22 bits name the page that holds the root table.

A walk starts with a one-cycle `start` pulse. The walker fetches one page table entry per level through a simple request/response memory port, and never has more than one read outstanding. It first reads the entry chosen by the upper ten bits of the address. If that entry points to a second table, it reads the entry chosen by the next ten bits. The walk ends with a one-cycle `done` pulse. At that point `found` tells whether a usable leaf entry was reached. If it was, `pte` and `paddr` carry the leaf and the translated address. The walker does not check access permissions.

Top module: `sv32_walker`

## Requirements
- R1: A root register write with bit 31 of the data set stores data[21:0], with the upper bits zero. A write with bit 31 clear stores zero. `satp_rd` shows the stored value from the cycle after the write. A start pulse in the same cycle as a write uses the old value.
- R2: While the stored root value is zero (bare mode), a start gives `done` one cycle later, with `found`=1, `pte`=0 and `paddr` equal to the zero-extended `vaddr`, and no memory read is made.
- R3: The level-1 entry is read at (root PPN << 12) + vaddr[31:22]*4. The level-0 entry is read at (next PPN << 12) + vaddr[21:12]*4. `mem_req` is a one-cycle pulse, and no new request is made until `mem_rvalid` returns.
- R4: An entry whose low four bits (X,W,R,V from bit 3 down to bit 0) equal 0001 is a pointer. At level 1 the walk continues with the table whose page number is PTE[31:10].
- R5: An entry at level 0 with V set and R or X set, and not reserved, is a leaf. The walk ends with `found`=1, `pte` equal to the entry and `paddr` = {PTE[31:10], vaddr[11:0]}.
- R6: A leaf at level 1 with PTE[19:10] zero is a superpage. `paddr` = {PTE[31:20], vaddr[21:0]}.
- R7: A leaf at level 1 with PTE[19:10] non-zero is misaligned and ends the walk with `found`=0. Whenever `found`=0 at `done`, `pte` and `paddr` are zero.
- R8: The encodings with W set and R clear (low bits 0101 and 1101) are reserved and end the walk with `found`=0 at either level.
- R9: An entry with V clear ends the walk with `found`=0. So does a pointer entry met at level 0.
- R10: A table page number not below MEM_PAGES, whether it is the root or a pointer target, ends the walk with `found`=0 without reading that table. Page number MEM_PAGES-1 is accepted.
- R11: A start while a walk is in progress is ignored. `done` is raised only while the walker is idle. `found`, `pte` and `paddr` hold their value until the next accepted start.
- R12: After reset, `satp_rd`=0, `done`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Root register write strobe |
| csr_wdata | input | 32 | Root register write data, bit 31 enables translation |
| satp_rd | output | 32 | Stored root register value |
| start | input | 1 | Begin a translation of `vaddr` |
| vaddr | input | 32 | Virtual address to translate |
| done | output | 1 | One-cycle pulse when a walk ends |
| found | output | 1 | A usable leaf was reached (or bare mode) |
| pte | output | 32 | Leaf entry, zero when not found or bare |
| paddr | output | 34 | Translated physical address |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 34 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The bench drives walks through several table shapes and checks each one:
- A pointer followed by a 4 KiB leaf shows whether both table index slices and the page offset land in the right bits.
- A superpage shows whether the 22-bit offset replaces the lower page number.
- A superpage with non-zero low page-number bits shows whether alignment is checked.
- Reserved encodings at both levels, a cleared valid bit, and a pointer met at the last level show whether the four kinds of entry are told apart.
- Root and pointer targets just inside and just outside physical memory show whether the bound is applied to both.
- Bare mode, and a second start issued during a walk, show whether reads are skipped or not doubled. The bench counts the memory requests to see this.

// File: rtl/sv32_walk_pkg.sv
package sv32_walk_pkg;
  localparam int VA_W    = 32;
  localparam int PTE_W   = 32;
  localparam int OFF_W   = 12;
  localparam int VPN_W   = 10;
  localparam int PPN_W   = 22;
  localparam int PA_W    = PPN_W + OFF_W;
  localparam int PPN_LSB = PTE_W - PPN_W;
  localparam int LOW_W   = VPN_W + OFF_W;
  localparam int ENT_SH  = 2;

  typedef enum logic [1:0] {
    K_INVALID,
    K_POINTER,
    K_LEAF,
    K_RESERVED
  } pte_kind_e;

  typedef enum logic {S_IDLE, S_WAIT} walk_state_e;

  function automatic pte_kind_e classify(input logic [PTE_W-1:0] e);
    if (!e[0])               return K_INVALID;
    else if (e[2] && !e[1])  return K_RESERVED;
    else if (e[3:1] == 3'b0) return K_POINTER;
    else                     return K_LEAF;
  endfunction

  function automatic logic [PPN_W-1:0] ppn_of(input logic [PTE_W-1:0] e);
    return e[PPN_LSB +: PPN_W];
  endfunction

  function automatic logic super_misaligned(input logic [PTE_W-1:0] e);
    return |e[PPN_LSB +: VPN_W];
  endfunction

  function automatic logic [PA_W-1:0] entry_addr(input logic [PPN_W-1:0] ppn,
                                                 input logic [VPN_W-1:0] vpn);
    return {ppn, {OFF_W{1'b0}}} + PA_W'({vpn, {ENT_SH{1'b0}}});
  endfunction

  function automatic logic [PA_W-1:0] leaf_pa(input logic [PTE_W-1:0] e,
                                              input logic [LOW_W-1:0] va_low,
                                              input logic lvl);
    if (lvl) return {e[PTE_W-1 -: PPN_W-VPN_W], va_low};
    else     return {e[PPN_LSB +: PPN_W], va_low[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/sv32_root_reg.sv
module sv32_root_reg
  import sv32_walk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [VA_W-1:0]  wdata,
  output logic [VA_W-1:0]  value,
  output logic [PPN_W-1:0] root_ppn,
  output logic             bare
);
  localparam int MODE_BIT = VA_W - 1;

  logic [PPN_W-1:0] ppn_q;
  logic             unused_mid;

  assign unused_mid = ^wdata[MODE_BIT-1:PPN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ppn_q <= '0;
    else if (we)  ppn_q <= wdata[MODE_BIT] ? wdata[PPN_W-1:0] : '0;
  end

  assign value    = VA_W'(ppn_q);
  assign root_ppn = ppn_q;
  assign bare     = (ppn_q == '0);
endmodule

// File: rtl/sv32_pte_decode.sv
module sv32_pte_decode
  import sv32_walk_pkg::*;
(
  input  logic [PTE_W-1:0] entry,
  output pte_kind_e        kind,
  output logic             misaligned,
  output logic [PPN_W-1:0] next_ppn
);
  assign kind       = classify(entry);
  assign misaligned = super_misaligned(entry);
  assign next_ppn   = ppn_of(entry);
endmodule

// File: rtl/sv32_walk_fsm.sv
module sv32_walk_fsm
  import sv32_walk_pkg::*;
#(
  parameter int unsigned MEM_PAGES = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic             bare,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  input  pte_kind_e        kind,
  input  logic             misaligned,
  input  logic [PPN_W-1:0] next_ppn,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  output logic             done,
  output logic             found,
  output logic [PTE_W-1:0] pte,
  output logic [PA_W-1:0]  paddr,
  output logic             busy
);
  function automatic logic ppn_ok(input logic [PPN_W-1:0] p);
    return 32'(p) < 32'(MEM_PAGES);
  endfunction

  walk_state_e      st_q;
  logic             lvl_q;
  logic [LOW_W-1:0] va_q;
  logic             req_q, done_q, found_q;
  logic [PA_W-1:0]  addr_q, pa_q;
  logic [PTE_W-1:0] pte_q;

  logic ev_accept, ev_bare, ev_root_bad, ev_root_go;
  logic ev_resp, ev_descend, ev_leaf_ok, ev_walk_fault;

  always_comb begin
    ev_accept     = (st_q == S_IDLE) && start;
    ev_bare       = ev_accept && bare;
    ev_root_bad   = ev_accept && !bare && !ppn_ok(root_ppn);
    ev_root_go    = ev_accept && !bare && ppn_ok(root_ppn);
    ev_resp       = (st_q == S_WAIT) && mem_rvalid;
    ev_descend    = ev_resp && (kind == K_POINTER) && lvl_q && ppn_ok(next_ppn);
    ev_leaf_ok    = ev_resp && (kind == K_LEAF) && !(lvl_q && misaligned);
    ev_walk_fault = ev_resp && !ev_descend && !ev_leaf_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      lvl_q   <= 1'b0;
      va_q    <= '0;
      req_q   <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      pte_q   <= '0;
      pa_q    <= '0;
    end else begin
      done_q <= 1'b0;
      req_q  <= 1'b0;
      if (ev_accept) va_q <= vaddr[LOW_W-1:0];
      if (ev_bare) begin
        done_q  <= 1'b1;
        found_q <= 1'b1;
        pte_q   <= '0;
        pa_q    <= PA_W'(vaddr);
      end
      if (ev_root_go) begin
        req_q  <= 1'b1;
        addr_q <= entry_addr(root_ppn, vaddr[VA_W-1 -: VPN_W]);
        lvl_q  <= 1'b1;
        st_q   <= S_WAIT;
      end
      if (ev_descend) begin
        req_q  <= 1'b1;
        addr_q <= entry_addr(next_ppn, va_q[OFF_W +: VPN_W]);
        lvl_q  <= 1'b0;
      end
      if (ev_leaf_ok) begin
        done_q  <= 1'b1;
        found_q <= 1'b1;
        pte_q   <= mem_rdata;
        pa_q    <= leaf_pa(mem_rdata, va_q, lvl_q);
        st_q    <= S_IDLE;
      end
      if (ev_root_bad || ev_walk_fault) begin
        done_q  <= 1'b1;
        found_q <= 1'b0;
        pte_q   <= '0;
        pa_q    <= '0;
        st_q    <= S_IDLE;
      end
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign done     = done_q;
  assign found    = found_q;
  assign pte      = pte_q;
  assign paddr    = pa_q;
  assign busy     = (st_q == S_WAIT);
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
  import sv32_walk_pkg::*;
#(
  parameter int unsigned MEM_PAGES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  output logic [31:0] satp_rd,
  input  logic        start,
  input  logic [31:0] vaddr,
  output logic        done,
  output logic        found,
  output logic [31:0] pte,
  output logic [33:0] paddr,
  output logic        mem_req,
  output logic [33:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  logic [PPN_W-1:0] root_ppn;
  logic             root_bare;
  pte_kind_e        ent_kind;
  logic             ent_misaligned;
  logic [PPN_W-1:0] ent_next_ppn;
  logic             walk_busy;

  sv32_root_reg u_root (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (csr_we),
    .wdata    (csr_wdata),
    .value    (satp_rd),
    .root_ppn (root_ppn),
    .bare     (root_bare)
  );

  sv32_pte_decode u_dec (
    .entry      (mem_rdata),
    .kind       (ent_kind),
    .misaligned (ent_misaligned),
    .next_ppn   (ent_next_ppn)
  );

  sv32_walk_fsm #(.MEM_PAGES(MEM_PAGES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vaddr      (vaddr),
    .root_ppn   (root_ppn),
    .bare       (root_bare),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .kind       (ent_kind),
    .misaligned (ent_misaligned),
    .next_ppn   (ent_next_ppn),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .done       (done),
    .found      (found),
    .pte        (pte),
    .paddr      (paddr),
    .busy       (walk_busy)
  );
endmodule

// File: rtl/sv32_walker_chk.sv
module sv32_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_we,
  input logic [31:0] csr_wdata,
  input logic [31:0] satp_rd,
  input logic        start,
  input logic        done,
  input logic        found,
  input logic [31:0] pte,
  input logic [33:0] paddr,
  input logic        mem_req,
  input logic        busy
);
  p_satp_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> satp_rd == ($past(csr_wdata[31]) ? 32'($past(csr_wdata[21:0])) : 32'd0));

  p_satp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> $stable(satp_rd));

  p_bare_quick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (satp_rd == 32'd0 && start && !busy) |=> (done && found && !mem_req));

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_req_in_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (pte == 32'd0 && paddr == 34'd0));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(found) && $stable(pte) && $stable(paddr)));
endmodule

bind sv32_walker sv32_walker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_we    (csr_we),
  .csr_wdata (csr_wdata),
  .satp_rd   (satp_rd),
  .start     (start),
  .done      (done),
  .found     (found),
  .pte       (pte),
  .paddr     (paddr),
  .mem_req   (mem_req),
  .busy      (walk_busy)
);

// File: tb/test_sv32_walker.sv
`timescale 1ns/1ps
module test_sv32_walker;
  localparam int PAGES = 1024;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] satp_rd;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0;
  logic        done, found;
  logic [31:0] pte;
  logic [33:0] paddr;
  logic        mem_req;
  logic [33:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] pmem [logic [33:0]];
  logic [33:0] req_log [0:3];
  int          nreq = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  logic        r_found;
  logic [31:0] r_pte;
  logic [33:0] r_pa;
  int          r_wait;

  always #2 clk = ~clk;

  sv32_walker #(.MEM_PAGES(PAGES)) i_sv32_walker (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .satp_rd(satp_rd), .start(start), .vaddr(vaddr), .done(done),
    .found(found), .pte(pte), .paddr(paddr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rst_n && mem_req) begin
        logic [33:0] a;
        a = mem_addr;
        if (nreq < 4) req_log[nreq] = a;
        nreq++;
        repeat (LAT - 1) @(negedge clk);
        mem_rdata  = pmem.exists(a) ? pmem[a] : 32'd0;
        mem_rvalid = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_root(input logic [31:0] d);
    @(negedge clk); csr_we = 1'b1; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va);
    nreq = 0;
    @(negedge clk); start = 1'b1; vaddr = va;
    @(negedge clk); start = 1'b0;
    r_wait = 0;
    while (!done && r_wait < 100) begin
      @(negedge clk);
      r_wait++;
    end
    r_found = found; r_pte = pte; r_pa = paddr;
  endtask

  task automatic t_reset;
    chk("R12 satp", 64'(satp_rd), 0);
    chk("R12 done", 64'(done), 0);
    chk("R12 req", 64'(mem_req), 0);
  endtask

  task automatic t_root_write;
    write_root(32'hFFC0_0010);
    chk("R1 mode set keeps low 22", 64'(satp_rd), 64'h10);
    write_root(32'h7FFF_FFFF);
    chk("R1 mode clear stores zero", 64'(satp_rd), 0);
  endtask

  task automatic t_bare;
    walk(32'hDEAD_BEEF);
    chk("R2 bare latency", 64'(r_wait), 0);
    chk("R2 bare found", 64'(r_found), 1);
    chk("R2 bare paddr", 64'(r_pa), 64'hDEAD_BEEF);
    chk("R2 bare pte", 64'(r_pte), 0);
    chk("R2 bare no reads", 64'(nreq), 0);
  endtask

  task automatic t_leaf4k;
    // vpn1=1, vpn0=3, offset 0xABC; root page 0x10, second table page 0x20
    walk(32'h0040_3ABC);
    chk("R3 level1 addr", 64'(req_log[0]), 64'h10004);
    chk("R4 level0 addr from pointer ppn", 64'(req_log[1]), 64'h2000C);
    chk("R5 found", 64'(r_found), 1);
    chk("R5 pte", 64'(r_pte), 64'h5540F);
    chk("R5 paddr", 64'(r_pa), 64'h155ABC);
  endtask

  task automatic t_super;
    walk(32'h0C12_3456);
    chk("R6 one read", 64'(nreq), 1);
    chk("R6 addr", 64'(req_log[0]), 64'h100C0);
    chk("R6 found", 64'(r_found), 1);
    chk("R6 paddr", 64'(r_pa), 64'h523456);
    walk(32'h0C40_0000);
    chk("R7 misaligned superpage", 64'(r_found), 0);
    chk("R7 zero pte", 64'(r_pte), 0);
  endtask

  task automatic t_bad_entries;
    walk(32'h0080_0000);
    chk("R8 reserved 0101 at level1", 64'(r_found), 0);
    walk(32'h0040_4000);
    chk("R8 reserved 1101 at level0", 64'(r_found), 0);
    chk("R8 two reads", 64'(nreq), 2);
    walk(32'h00C0_0000);
    chk("R9 V clear", 64'(r_found), 0);
    walk(32'h0040_5000);
    chk("R9 pointer at level0", 64'(r_found), 0);
    chk("R9 pointer at level0 reads", 64'(nreq), 2);
  endtask

  task automatic t_bounds;
    walk(32'h0100_0000);
    chk("R10 pointer target out of range", 64'(r_found), 0);
    chk("R10 no read of bad table", 64'(nreq), 1);
    walk(32'h0140_0000);
    chk("R10 last page accepted", 64'(r_found), 1);
    chk("R10 last page addr", 64'(req_log[1]), 64'h3FF000);
    chk("R10 last page paddr", 64'(r_pa), 64'h7000);
    write_root(32'h8000_0400);
    walk(32'h0040_3ABC);
    chk("R10 root out of range", 64'(r_found), 0);
    chk("R10 root no read", 64'(nreq), 0);
    write_root(32'h8000_0010);
  endtask

  task automatic t_busy_start;
    nreq = 0;
    @(negedge clk); start = 1'b1; vaddr = 32'h0040_3ABC;
    @(negedge clk); vaddr = 32'h0C12_3456;
    @(negedge clk); start = 1'b0;
    r_wait = 0;
    while (!done && r_wait < 100) begin @(negedge clk); r_wait++; end
    chk("R11 first walk result", 64'(paddr), 64'h155ABC);
    chk("R11 done idle pulse", 64'(done), 1);
    @(negedge clk);
    chk("R11 done one cycle", 64'(done), 0);
    repeat (10) @(negedge clk);
    chk("R11 extra start ignored", 64'(nreq), 2);
    chk("R11 result held", 64'(paddr), 64'h155ABC);
  endtask

  initial begin
    pmem[34'h10004] = (32'h020 << 10) | 32'h1;
    pmem[34'h2000C] = (32'h155 << 10) | 32'hF;
    pmem[34'h100C0] = (32'h400 << 10) | 32'hB;
    pmem[34'h100C4] = (32'h401 << 10) | 32'h3;
    pmem[34'h10008] = (32'h020 << 10) | 32'h5;
    pmem[34'h20010] = (32'h030 << 10) | 32'hD;
    pmem[34'h1000C] = (32'h020 << 10) | 32'h2;
    pmem[34'h20014] = (32'h020 << 10) | 32'h1;
    pmem[34'h10010] = (32'd1024 << 10) | 32'h1;
    pmem[34'h10014] = (32'd1023 << 10) | 32'h1;
    pmem[34'h3FF000] = (32'h007 << 10) | 32'h3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_root_write;
    t_bare;
    write_root(32'h8000_0010);
    t_leaf4k;
    t_super;
    t_bad_entries;
    t_bounds;
    t_busy_start;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule